// File: doc/BRIEF.md
# Two-Digit Seconds Countdown Timer

This block is a seconds countdown timer. It runs from a 100 MHz system clock. A prescaler inside the block counts enabled clock cycles and raises a one-cycle tick once per second. All registers run on the system clock, and the tick acts only as a clock enable. Two BCD digits, tens and units, are loaded with 30 at reset. Each tick lowers the value by one second. When the value reaches 00 it stays there. The block drives both raw BCD digits and two active-low seven-segment patterns, ready for two separate display digits.

The digit logic is a two-state machine. In state `ST_COUNT` the digits are still above zero. On a tick with a value above 01, the machine takes the transition *step*: it stays in `ST_COUNT` and decrements. On a tick at 01, it takes the transition *expire*: it loads 00 and moves to `ST_ZERO`. In `ST_ZERO` the machine takes the transition *hold* on every cycle and leaves only on reset. Reset is the transition *reload*, from any state. It enters `ST_COUNT`, or enters `ST_ZERO` if the start value is set to 00. The `en` input freezes the prescaler and the digits together. The prescaler length is a parameter, 100,000,000 by default, so a short value can be used to see the whole sequence quickly.

Top module: `cdt_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the digits load tens=3 and units=0 and the prescaler clears. After `rst` goes low with `en` held high, the first decrement lands on the CYCLES_PER_TICK-th rising edge.
- R2: With `en` held high, the digits change exactly once every CYCLES_PER_TICK rising edges and never in between.
- R3: Each change lowers the value by exactly one second. When units is 0 and the value is not 00, the next tick sets units to 9 and lowers tens by one (30 goes to 29, and 10 goes to 09).
- R4: While `en` is low, the digits and the prescaler phase are frozen. The count resumes from the same phase when `en` returns high.
- R5: Once the value reaches 00 it stays at 00 under any further enabled cycles until reset. `done` is high exactly when both digits are 0.
- R6: `tens_seg` and `units_seg` are active-low, with bit 6 = g down to bit 0 = a. The hex codes for digits 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00, 10.
- R7: `tens_bcd` and `units_bcd` always hold valid BCD (0 to 9) and follow the sequence 30, 29, ..., 01, 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous reset, active high; reloads the start value |
| en | input | 1 | Count enable for the prescaler and the digits |
| tens_bcd | output | 4 | Tens digit, BCD |
| units_bcd | output | 4 | Units digit, BCD |
| tens_seg | output | 7 | Tens digit segments, active-low, gfedcba |
| units_seg | output | 7 | Units digit segments, active-low, gfedcba |
| done | output | 1 | High while the value is 00 |

## Verification
A wrong prescaler phase shows at the ports as a decrement that comes one or more cycles early or late. It is visible on the first tick after reset or after an `en` pause. A wrong borrow or a corrupted digit register shows on the very next tick as a skipped or non-BCD value, and the segment outputs mismatch in the same cycle. A state machine stuck in the wrong state shows as `done` disagreeing with a 00 value, or as a wrap past 00, within one tick period.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int SEG_W = 7;
    localparam int BCD_W = 4;
    localparam int NUM_DIGITS = 2;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic [0:0] {
        ST_COUNT = 1'b0,
        ST_ZERO  = 1'b1
    } cnt_state_e;

    localparam bcd_t BCD_NINE = 4'd9;
    localparam seg_t SEG_BLANK = 7'h7F;

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
    parameter int CYCLES_PER_TICK = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);

    localparam int CNT_W = (CYCLES_PER_TICK > 2) ? $clog2(CYCLES_PER_TICK) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_TICK - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);
    assign tick    = en && at_last;

    // phase counter advances only on enabled cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cdt_digits.sv
module cdt_digits
    import cdt_pkg::*;
#(
    parameter int START_TENS  = 3,
    parameter int START_UNITS = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output bcd_t tens,
    output bcd_t units,
    output logic done
);

    localparam bcd_t INIT_TENS  = bcd_t'(START_TENS);
    localparam bcd_t INIT_UNITS = bcd_t'(START_UNITS);
    localparam cnt_state_e INIT_STATE =
        (START_TENS == 0 && START_UNITS == 0) ? ST_ZERO : ST_COUNT;

    cnt_state_e state_q, state_d;
    bcd_t       tens_q, tens_d;
    bcd_t       units_q, units_d;
    logic       last_second;

    assign last_second = (tens_q == '0) && (units_q == 4'd1);

    // next state and next digits
    always_comb begin
        state_d = state_q;
        tens_d  = tens_q;
        units_d = units_q;
        unique case (state_q)
            ST_COUNT: begin
                if (tick) begin
                    if (units_q != '0) begin
                        units_d = units_q - 1'b1;
                    end else begin
                        units_d = BCD_NINE;
                        tens_d  = tens_q - 1'b1;
                    end
                    if (last_second) begin
                        state_d = ST_ZERO;
                    end
                end
            end
            ST_ZERO: begin
                state_d = ST_ZERO;
            end
            default: begin
                state_d = INIT_STATE;
            end
        endcase
    end

    // state and digit registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= INIT_STATE;
            tens_q  <= INIT_TENS;
            units_q <= INIT_UNITS;
        end else begin
            state_q <= state_d;
            tens_q  <= tens_d;
            units_q <= units_d;
        end
    end

    // outputs
    always_comb begin
        tens  = tens_q;
        units = units_q;
        unique case (state_q)
            ST_ZERO:  done = 1'b1;
            default:  done = 1'b0;
        endcase
    end

endmodule

// File: rtl/cdt_seg7.sv
module cdt_seg7
    import cdt_pkg::*;
(
    input  bcd_t digit,
    output seg_t seg_n
);

    // active-low, bit 6 = g ... bit 0 = a
    always_comb begin
        unique case (digit)
            4'd0:    seg_n = 7'h40;
            4'd1:    seg_n = 7'h79;
            4'd2:    seg_n = 7'h24;
            4'd3:    seg_n = 7'h30;
            4'd4:    seg_n = 7'h19;
            4'd5:    seg_n = 7'h12;
            4'd6:    seg_n = 7'h02;
            4'd7:    seg_n = 7'h78;
            4'd8:    seg_n = 7'h00;
            4'd9:    seg_n = 7'h10;
            default: seg_n = SEG_BLANK;
        endcase
    end

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CYCLES_PER_TICK = 100_000_000,
    parameter int START_TENS      = 3,
    parameter int START_UNITS     = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [3:0] tens_bcd,
    output logic [3:0] units_bcd,
    output logic [6:0] tens_seg,
    output logic [6:0] units_seg,
    output logic       done
);

    logic tick_w;
    bcd_t digit_v [NUM_DIGITS];
    seg_t seg_v   [NUM_DIGITS];

    cdt_prescale #(
        .CYCLES_PER_TICK(CYCLES_PER_TICK)
    ) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick_w)
    );

    cdt_digits #(
        .START_TENS (START_TENS),
        .START_UNITS(START_UNITS)
    ) u_digits (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_w),
        .tens  (digit_v[1]),
        .units (digit_v[0]),
        .done  (done)
    );

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
        cdt_seg7 u_seg (
            .digit (digit_v[g]),
            .seg_n (seg_v[g])
        );
    end

    assign tens_bcd  = digit_v[1];
    assign units_bcd = digit_v[0];
    assign tens_seg  = seg_v[1];
    assign units_seg = seg_v[0];

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int START_TENS  = 3,
    parameter int START_UNITS = 0
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       tick,
    input logic [3:0] tens_bcd,
    input logic [3:0] units_bcd,
    input logic       done
);

    logic [6:0] secs;
    assign secs = 7'(tens_bcd) * 7'd10 + 7'(units_bcd);

    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (tens_bcd == 4'(START_TENS)) && (units_bcd == 4'(START_UNITS)));

    p_change_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!$stable({tens_bcd, units_bcd}) && !$past(rst)) |-> $past(tick));

    p_one_second_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!$stable({tens_bcd, units_bcd}) && !$past(rst)) |-> (secs + 7'd1 == $past(secs)));

    p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable({tens_bcd, units_bcd}));

    p_done_zero_r5: assert property (@(posedge clk) disable iff (rst)
        done == (tens_bcd == 4'd0 && units_bcd == 4'd0));

    p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> done && $stable({tens_bcd, units_bcd}));

    p_bcd_range_r7: assert property (@(posedge clk) disable iff (rst)
        (tens_bcd <= 4'd9) && (units_bcd <= 4'd9));

endmodule

bind cdt_timer cdt_timer_chk #(
    .START_TENS (START_TENS),
    .START_UNITS(START_UNITS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tick      (tick_w),
    .tens_bcd  (tens_bcd),
    .units_bcd (units_bcd),
    .done      (done)
);

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;

    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] tens_bcd, units_bcd;
    logic [6:0] tens_seg, units_seg;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cdt_timer #(
        .CYCLES_PER_TICK(N),
        .START_TENS     (3),
        .START_UNITS    (0)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tens_bcd  (tens_bcd),
        .units_bcd (units_bcd),
        .tens_seg  (tens_seg),
        .units_seg (units_seg),
        .done      (done)
    );

    // R6 table, active-low gfedcba
    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h40;
            1: return 7'h79;
            2: return 7'h24;
            3: return 7'h30;
            4: return 7'h19;
            5: return 7'h12;
            6: return 7'h02;
            7: return 7'h78;
            8: return 7'h00;
            9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_value(input string req, input int secs);
        chk(req, "tens", int'(tens_bcd), secs / 10);
        chk(req, "units", int'(units_bcd), secs % 10);
        chk("R6", "tens_seg", int'(tens_seg), int'(exp_seg(secs / 10)));
        chk("R6", "units_seg", int'(units_seg), int'(exp_seg(secs % 10)));
        chk("R5", "done", int'(done), (secs == 0) ? 1 : 0);
    endtask

    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        cycles(2);
        rst = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset_state();
        do_reset();
        chk_value("R1", 30);
    endtask

    // R1/R2/R3: first tick timing and borrow 30 -> 29
    task automatic t_first_tick();
        do_reset();
        en = 1'b1;
        cycles(N - 1);
        chk_value("R2", 30);
        cycles(1);
        chk_value("R3", 29);
        cycles(N - 1);
        chk_value("R2", 29);
        cycles(1);
        chk_value("R2", 28);
    endtask

    // R4: enable low freezes digits and prescaler phase
    task automatic t_freeze();
        do_reset();
        en = 1'b1;
        cycles(2);
        en = 1'b0;
        cycles(3 * N + 1);
        chk_value("R4", 30);
        en = 1'b1;
        cycles(N - 3);
        chk_value("R4", 30);
        cycles(1);
        chk_value("R4", 29);
    endtask

    // R1: reset in mid-count reloads and clears the phase
    task automatic t_reset_midway();
        do_reset();
        en = 1'b1;
        cycles(5 * N + 1);
        chk_value("R3", 25);
        rst = 1'b1;
        cycles(1);
        rst = 1'b0;
        chk_value("R1", 30);
        cycles(N - 1);
        chk_value("R1", 30);
        cycles(1);
        chk_value("R1", 29);
    endtask

    // R7/R3/R5: full sequence down to 00 and hold
    task automatic t_full_run();
        do_reset();
        en = 1'b1;
        for (int s = 29; s >= 0; s--) begin
            cycles(N);
            chk_value("R7", s);
        end
        cycles(5 * N);
        chk_value("R5", 0);
        en = 1'b0;
        cycles(3);
        chk_value("R5", 0);
    endtask

    initial begin
        t_reset_state();
        t_first_tick();
        t_freeze();
        t_reset_midway();
        t_full_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule